// File: doc/BRIEF.md
# GPIO Register Bank with Change Interrupt

This block is an eight-pin general-purpose I/O port governed by four byte-wide registers: a direction register, a drive-value register, a read-inversion register, and a read-only view of the pin levels. Software reaches the registers through a simple parallel port. A two-bit index selects the register. A write strobe loads write data into the selected register on the next clock edge. Read data always shows the selected register combinationally. A read strobe matters only for the pin register.

Pin levels pass through a two-flop synchronizer before anything else uses them. Each pin has an output-enable and an output-value signal for an external pad. The pad driver and its pull-up are outside the block.

An interrupt reports when any pin set as an input no longer matches a stored reference. The reference is the set of synchronized levels captured by the last read strobe on the pin register. The interrupt drops again when the pin goes back to the reference level. It also drops when software reads the pin register, because that read refreshes the reference. The interrupt is modelled as an open-drain pull enable: 1 means the shared line is pulled low.

Top module: `gpio_bank`

## Requirements
- R1: After reset the registers read as follows: pin view FFh while all pins are high, drive FFh, inversion 00h, direction FFh. No pad is enabled and the interrupt pull is 0.
- R2: Index 0 reads the synchronized pin levels for every pin, whatever its direction. A pin change appears in read data after two clock edges.
- R3: A write strobe with index 0 changes no register. The drive, inversion and direction registers keep their values, and index 0 still reads the pin levels.
- R4: Index 0 read data is the synchronized pins XOR the inversion register (index 2). An inversion bit of 1 flips that bit and 0 passes it. Inversion has no effect on the pads or the interrupt.
- R5: The direction register is index 3. A direction bit of 0 sets pad_oe to 1 and drives pad_out from the matching drive-register bit. A direction bit of 1 sets pad_oe to 0 and pad_out to 0.
- R6: Index 1 reads the drive register contents, not the pin level, even when an external source holds the pin at another value.
- R7: irq_pull goes to 1 when a synchronized pin whose direction bit is 1 differs from the reference. Pins with direction bit 0 never raise it.
- R8: irq_pull returns to 0 once every input pin is back at its reference level.
- R9: A read strobe with index 0 copies the current synchronized pins into the reference, so irq_pull is 0 on the following cycle if the pins hold still. The reference is FFh after reset.
- R10: Changing a pin from output (direction 0) to input (direction 1) raises irq_pull at once if its level differs from the reference.
- R11: A write to index 1, 2 or 3 takes effect at the clock edge that samples the strobe. Read data for the current index is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw pin levels from the pads |
| reg_idx | input | 2 | Register index: 0 pins, 1 drive, 2 inversion, 3 direction |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; refreshes the interrupt reference when reg_idx is 0 |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for reg_idx |
| pad_oe | output | 8 | Per-pin output enable, 1 drives the pad |
| pad_out | output | 8 | Per-pin output value |
| irq_pull | output | 1 | Interrupt pull enable, 1 pulls the active-low line down |

## Verification
The hardest case to reach is a false interrupt caused by a direction change. The reference must hold one level while a pin runs as an output with the opposite level on its pad, and then the pin is turned back into an input. The stimulus first takes a reference with the pin high. It then makes the pin an output and lowers the external level, and checks that the interrupt stays quiet. Finally it sets the direction bit back to input and checks that the interrupt rises in the same cycle. Before that, the bench checks clearing both by the pin returning and by a reference-refreshing read, and it keeps the pins still across each read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    IDX_PINS   = 2'd0,
    IDX_DRIVE  = 2'd1,
    IDX_INVERT = 2'd2,
    IDX_DIR    = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_s
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [1:0]   warm_cnt;
  logic         warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign pin_s = sync_q;

  // cycles since reset, saturating, used to gate the latency check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm_cnt <= '0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd2);

  assert_sync_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (pin_s == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_idx,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_s,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out
);
  logic [W-1:0] drive_q;
  logic [W-1:0] inv_q;
  logic         wr_drive;
  logic         wr_inv;
  logic         wr_dir;
  logic         wr_pins;

  function automatic logic [W-1:0] shown_pins(input logic [W-1:0] lvl,
                                               input logic [W-1:0] inv);
    return lvl ^ inv;
  endfunction

  function automatic logic [W-1:0] driven_value(input logic [W-1:0] drv,
                                                input logic [W-1:0] dir);
    return drv & ~dir;
  endfunction

  assign wr_drive = wr_en && (reg_idx == IDX_DRIVE);
  assign wr_inv   = wr_en && (reg_idx == IDX_INVERT);
  assign wr_dir   = wr_en && (reg_idx == IDX_DIR);
  assign wr_pins  = wr_en && (reg_idx == IDX_PINS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '1;
      inv_q   <= '0;
      dir_q   <= '1;
    end else begin
      if (wr_drive) drive_q <= wr_data;
      if (wr_inv)   inv_q   <= wr_data;
      if (wr_dir)   dir_q   <= wr_data;
    end
  end

  always_comb begin
    unique case (reg_idx)
      IDX_PINS:   rd_data = shown_pins(pin_s, inv_q);
      IDX_DRIVE:  rd_data = drive_q;
      IDX_INVERT: rd_data = inv_q;
      default:    rd_data = dir_q;
    endcase
  end

  assign pad_oe  = ~dir_q;
  assign pad_out = driven_value(drive_q, dir_q);

  assert_pin_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pins |=> $stable({drive_q, inv_q, dir_q}));

  assert_drive_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drive |=> (drive_q == $past(wr_data)));

  assert_dir_sets_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pad_oe == ~$past(wr_data)));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] dir_q,
  input  logic         snap_fire,
  output logic         irq_pull
);
  logic [W-1:0] ref_q;
  logic [W-1:0] pending;

  function automatic logic [W-1:0] changed_inputs(input logic [W-1:0] lvl,
                                                  input logic [W-1:0] refv,
                                                  input logic [W-1:0] dir);
    return (lvl ^ refv) & dir;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ref_q <= '1;
    else if (snap_fire) ref_q <= pin_s;
  end

  assign pending  = changed_inputs(pin_s, ref_q, dir_q);
  assign irq_pull = |pending;

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snap_fire |=> (!irq_pull || (pin_s != $past(pin_s))));

  assert_quiet_on_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_s == ref_q) |-> !irq_pull);

  assert_outputs_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == '0) |-> !irq_pull);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [1:0]   reg_idx,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic         irq_pull
);
  logic [W-1:0] pin_s;
  logic [W-1:0] dir_q;
  logic         snap_fire;

  assign snap_fire = rd_en && (reg_idx == IDX_PINS);

  gpio_sync #(.W(W)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .pin_s (pin_s)
  );

  gpio_regs #(.W(W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_idx (reg_idx),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pin_s   (pin_s),
    .rd_data (rd_data),
    .dir_q   (dir_q),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  gpio_irq #(.W(W)) irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_s     (pin_s),
    .dir_q     (dir_q),
    .snap_fire (snap_fire),
    .irq_pull  (irq_pull)
  );

  // a pad may only be driven where the direction bit marks an output (R5)
  assert_input_pads_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin_i = '1;
  logic [1:0]   reg_idx = 2'd0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] pad_oe;
  logic [W-1:0] pad_out;
  logic         irq_pull;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_idx(reg_idx),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .pad_oe(pad_oe), .pad_out(pad_out), .irq_pull(irq_pull)
  );

  // {inversion, direction, drive, pins, exp_read0, exp_oe, exp_padout}
  localparam logic [55:0] VEC [5] = '{
    {8'h00, 8'hFF, 8'hFF, 8'hA5, 8'hA5, 8'h00, 8'h00},
    {8'hFF, 8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h00, 8'h00},
    {8'h0F, 8'h00, 8'h3C, 8'hF0, 8'hFF, 8'hFF, 8'h3C},
    {8'h81, 8'hF0, 8'hAA, 8'h66, 8'hE7, 8'h0F, 8'h0A},
    {8'h00, 8'h55, 8'hC3, 8'h00, 8'h00, 8'hAA, 8'h82}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [W-1:0] d);
    @(negedge clk);
    reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // read without strobe: combinational view only
  task automatic peek(input logic [1:0] idx, output logic [W-1:0] d);
    @(negedge clk);
    reg_idx = idx;
    #1 d = rd_data;
  endtask

  // read with strobe: refreshes the reference when idx is 0
  task automatic rd(input logic [1:0] idx, output logic [W-1:0] d);
    @(negedge clk);
    reg_idx = idx; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_pins(input logic [W-1:0] p);
    @(negedge clk);
    pin_i = p;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(2'd0, v); check("R1 pins", v, 8'hFF);
    peek(2'd1, v); check("R1 drive", v, 8'hFF);
    peek(2'd2, v); check("R1 inversion", v, 8'h00);
    peek(2'd3, v); check("R1 direction", v, 8'hFF);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 irq", {7'd0, irq_pull}, 8'h00);

    // R2 R4 R5 R11 vector table
    for (int i = 0; i < 5; i++) begin
      logic [55:0] e;
      e = VEC[i];
      wr(2'd2, e[55:48]);
      wr(2'd3, e[47:40]);
      wr(2'd1, e[39:32]);
      set_pins(e[31:24]);
      rd(2'd0, v);   check("R2 R4 pin read", v, e[23:16]);
      peek(2'd1, v); check("R11 drive readback", v, e[39:32]);
      peek(2'd3, v); check("R11 direction readback", v, e[47:40]);
      check("R5 pad_oe", pad_oe, e[15:8]);
      check("R5 pad_out", pad_out, e[7:0]);
    end

    // R2 latency: one edge after change is still old value
    wr(2'd2, 8'h00);
    set_pins(8'h11);
    @(negedge clk); pin_i = 8'h22; reg_idx = 2'd0;
    @(negedge clk); #1 check("R2 one edge old", rd_data, 8'h11);
    @(negedge clk); #1 check("R2 two edges new", rd_data, 8'h22);

    // R3 write to index 0 ignored
    wr(2'd1, 8'h5C); wr(2'd2, 8'h0F); wr(2'd3, 8'hF0);
    wr(2'd0, 8'h00);
    peek(2'd1, v); check("R3 drive kept", v, 8'h5C);
    peek(2'd2, v); check("R3 inversion kept", v, 8'h0F);
    peek(2'd3, v); check("R3 direction kept", v, 8'hF0);
    peek(2'd0, v); check("R3 pins still shown", v, 8'h2D);

    // R6 drive register read ignores pin level
    wr(2'd3, 8'h00); wr(2'd1, 8'h0F); wr(2'd2, 8'h00);
    set_pins(8'hF0);
    peek(2'd1, v); check("R6 drive not pin", v, 8'h0F);
    peek(2'd0, v); check("R6 pin view", v, 8'hF0);

    // interrupt sequence
    wr(2'd3, 8'hFF);
    set_pins(8'h00);
    rd(2'd0, v);
    check("R9 irq cleared by read", {7'd0, irq_pull}, 8'h00);
    set_pins(8'h04);
    check("R7 irq on input change", {7'd0, irq_pull}, 8'h01);
    wr(2'd2, 8'hFF);
    check("R4 inversion leaves irq", {7'd0, irq_pull}, 8'h01);
    wr(2'd2, 8'h00);
    set_pins(8'h00);
    check("R8 irq clears on return", {7'd0, irq_pull}, 8'h00);
    set_pins(8'h04);
    check("R7 irq again", {7'd0, irq_pull}, 8'h01);
    rd(2'd0, v);
    check("R9 read clears irq", {7'd0, irq_pull}, 8'h00);

    // reference is 04; make bit 2 an output and lower the pin
    wr(2'd3, 8'hFB);
    set_pins(8'h00);
    check("R7 output pin silent", {7'd0, irq_pull}, 8'h00);
    wr(2'd3, 8'hFF);
    check("R10 output to input mismatch", {7'd0, irq_pull}, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule